// File: doc/BRIEF.md
# Dual-Source DMA Bus Arbiter

This block is a DMA engine that takes the system bus away from the CPU for two kinds of transfer. The first is a page copy. A single write to a trigger strobe, together with a page number P, starts it. The engine then reads the 256 bytes at addresses P00 to PFF in ascending order and writes each byte to one fixed output-port address. The second is a one-byte sample fetch, which the audio playback channel asks for with a request pulse. While either transfer runs, the engine holds the CPU ready line low. In each cycle it chooses what goes on the bus: the CPU's own address, a page source address, the output port or the sample address.

The page copy uses two cycles per byte, a read followed by a write. Its read slots always fall on even bus cycles, and the engine brings out a free-running even/odd cycle flag so that this is visible. A sample request that arrives during a copy takes over the next page read slot. After the stolen slot comes one realignment cycle, with the CPU address on the bus. The page read that was displaced then runs with its original source address. Each steal makes the copy two cycles longer, and neither stream loses or corrupts a byte. A sample request that arrives while the engine is idle halts the CPU for three cycles and does the read in the last of them.

Top module: `dual_dma_arbiter`

## Requirements
- R1: While reset is held and just after it, cpu_rdy is 1, bus_rw is 1 (read), bus_addr equals cpu_addr and smp_valid is 0.
- R2: cpu_rdy is 0 in the same cycle in which trig_we is 1 while idle. In the next two cycles bus_addr equals cpu_addr and bus_rw is 1.
- R3: odd_cycle toggles every cycle. Every page read takes place with odd_cycle = 0. The first page read comes 3 cycles after the trigger cycle if odd_cycle was 1 in the trigger cycle, and 4 cycles after it otherwise, because of one alignment cycle.
- R4: A copy makes 256 read/write pairs. The reads go to {P, 0x00} through {P, 0xFF} in order. Each read is followed at once by a write (bus_rw = 0) to OUT_ADDR (default 0x2004), and bus_wdata carries the byte read in the previous cycle.
- R5: cpu_rdy returns to 1 in the cycle right after the final write. A copy with no steals holds cpu_rdy low for 515 cycles, or 516 when an alignment cycle is inserted, counting the trigger cycle.
- R6: A smp_req pulse in idle cycle t gives cpu_rdy = 0 in cycles t+2 to t+4. bus_addr equals cpu_addr in cycles t+2 and t+3, and a read of smp_addr takes place in cycle t+4. In cycle t+5, smp_valid is 1 for exactly one cycle and smp_data holds the byte that was read.
- R7: A sample request that is pending during a copy replaces the next page read slot, never a write. The next cycle shows cpu_addr on the bus, and the cycle after that repeats the displaced page read with the same source address.
- R8: Each embedded sample fetch makes the copy 2 cycles longer. The copied bytes and the sample byte stay intact.
- R9: A trig_we pulse while the engine is busy is ignored, and the copy that is running continues with its original page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Write strobe for the page-copy trigger |
| trig_page | input | 8 | Source page number P |
| smp_req | input | 1 | Sample fetch request pulse |
| smp_addr | input | 16 | Address of the sample byte |
| cpu_addr | input | 16 | Address the CPU is currently driving |
| rd_data | input | 8 | Read data returned from memory |
| cpu_rdy | output | 1 | CPU ready; 0 halts the CPU |
| bus_addr | output | 16 | System bus address |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 8 | Write data, valid when bus_rw is 0 |
| smp_data | output | 8 | Fetched sample byte |
| smp_valid | output | 1 | One-cycle strobe for smp_data |
| odd_cycle | output | 1 | Bus cycle parity flag |

## Verification
A bad sequencer state or a wrong page offset shows up on the bus within one or two cycles. The bus then carries an address that is out of order, a page read on an odd cycle, or a write that does not come right after its read. A stale hold register shows up at once, as bus_wdata different from the byte read in the cycle before. A lost or duplicated steal stays hidden until the copy ends, and then the ready-low length differs from 515 plus alignment plus two per steal. The bench therefore checks every bus cycle of each copy and the full length of each copy.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HALT_A,
    ST_HALT_B,
    ST_ALIGN,
    ST_PG_RD,
    ST_PG_WR,
    ST_SM_STEAL,
    ST_REALIGN,
    ST_SM_WAIT_A,
    ST_SM_WAIT_B,
    ST_SM_RD
  } arb_state_t;

  // next-cycle parity differs from the parity reserved for page reads
  function automatic logic needs_align(input logic next_odd, input logic read_odd);
    return next_odd != read_odd;
  endfunction

  // a read slot goes to a pending sample before the page
  function automatic arb_state_t pick_slot(input logic pend);
    return pend ? ST_SM_STEAL : ST_PG_RD;
  endfunction

  function automatic logic is_sample_read(input arb_state_t s);
    return (s == ST_SM_STEAL) || (s == ST_SM_RD);
  endfunction
endpackage

// File: rtl/dma_parity_tracker.sv
`timescale 1ns/1ps
module dma_parity_tracker (
  input  logic clk,
  input  logic rst_n,
  output logic odd_cycle
);
  always_ff @(posedge clk) begin
    if (!rst_n) odd_cycle <= 1'b0;
    else        odd_cycle <= ~odd_cycle;
  end
endmodule

// File: rtl/dma_sample_latch.sv
`timescale 1ns/1ps
module dma_sample_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= req | (pend & ~take);
  end
endmodule

// File: rtl/dma_page_seq.sv
`timescale 1ns/1ps
module dma_page_seq
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 256,
  parameter bit READ_ODD   = 1'b0,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  input  logic              smp_pend,
  input  logic              odd_cycle,
  output arb_state_t        state,
  output logic [ADDR_W-1:0] src_addr,
  output logic              last_byte
);
  arb_state_t        nxt;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  function automatic logic [ADDR_W-1:0] page_src(input logic [PAGE_W-1:0] pg,
                                                 input logic [OFF_W-1:0] off);
    return {pg, off};
  endfunction

  assign src_addr  = page_src(page_q, off_q);
  assign last_byte = (off_q == OFF_W'(PAGE_BYTES - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (trig_we)       nxt = ST_HALT_A;
        else if (smp_pend) nxt = ST_SM_WAIT_A;
      end
      ST_HALT_A:    nxt = ST_HALT_B;
      ST_HALT_B:    nxt = needs_align(~odd_cycle, READ_ODD) ? ST_ALIGN : pick_slot(smp_pend);
      ST_ALIGN:     nxt = pick_slot(smp_pend);
      ST_PG_RD:     nxt = ST_PG_WR;
      ST_PG_WR:     nxt = last_byte ? ST_IDLE : pick_slot(smp_pend);
      ST_SM_STEAL:  nxt = ST_REALIGN;
      ST_REALIGN:   nxt = pick_slot(smp_pend);
      ST_SM_WAIT_A: nxt = ST_SM_WAIT_B;
      ST_SM_WAIT_B: nxt = ST_SM_RD;
      ST_SM_RD:     nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      page_q <= '0;
      off_q  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && trig_we) begin
        page_q <= trig_page;
        off_q  <= '0;
      end else if (state == ST_PG_WR && !last_byte) begin
        off_q <= off_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_bus_drive.sv
`timescale 1ns/1ps
module dma_bus_drive
  import dma_arb_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arb_state_t        state,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid
);
  logic [DATA_W-1:0] byte_q;

  always_comb begin
    bus_addr = cpu_addr;
    bus_rw   = 1'b1;
    unique case (state)
      ST_PG_RD:              bus_addr = src_addr;
      ST_PG_WR: begin
        bus_addr = OUT_ADDR;
        bus_rw   = 1'b0;
      end
      ST_SM_STEAL, ST_SM_RD: bus_addr = smp_addr;
      default:               bus_addr = cpu_addr;
    endcase
  end

  assign bus_wdata = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q    <= '0;
      smp_data  <= '0;
      smp_valid <= 1'b0;
    end else begin
      if (state == ST_PG_RD) byte_q <= rd_data;
      smp_valid <= is_sample_read(state);
      if (is_sample_read(state)) smp_data <= rd_data;
    end
  end
endmodule

// File: rtl/dual_dma_arbiter.sv
`timescale 1ns/1ps
module dual_dma_arbiter
  import dma_arb_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                PAGE_BYTES = 256,
  parameter logic [ADDR_W-1:0] OUT_ADDR   = 16'h2004,
  parameter bit                READ_ODD   = 1'b0,
  localparam int               PAGE_W     = ADDR_W - $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  input  logic              smp_req,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cpu_rdy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid,
  output logic              odd_cycle
);
  arb_state_t        state;
  logic [ADDR_W-1:0] src_addr;
  logic              last_byte;
  logic              smp_pend;

  // named events for the checker
  logic ev_pg_rd, ev_pg_wr, ev_steal, ev_realign, ev_smp_rd, ev_last_wr, busy;
  assign ev_pg_rd   = (state == ST_PG_RD);
  assign ev_pg_wr   = (state == ST_PG_WR);
  assign ev_steal   = (state == ST_SM_STEAL);
  assign ev_realign = (state == ST_REALIGN);
  assign ev_smp_rd  = is_sample_read(state);
  assign ev_last_wr = ev_pg_wr & last_byte;
  assign busy       = (state != ST_IDLE);

  assign cpu_rdy = ~busy & ~trig_we;

  dma_parity_tracker u_par (
    .clk(clk), .rst_n(rst_n), .odd_cycle(odd_cycle)
  );

  dma_sample_latch u_pend (
    .clk(clk), .rst_n(rst_n), .req(smp_req), .take(ev_smp_rd), .pend(smp_pend)
  );

  dma_page_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .READ_ODD(READ_ODD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_page(trig_page),
    .smp_pend(smp_pend), .odd_cycle(odd_cycle), .state(state),
    .src_addr(src_addr), .last_byte(last_byte)
  );

  dma_bus_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_ADDR(OUT_ADDR)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .state(state), .src_addr(src_addr),
    .smp_addr(smp_addr), .cpu_addr(cpu_addr), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
    .smp_data(smp_data), .smp_valid(smp_valid)
  );
endmodule

// File: rtl/dual_dma_arbiter_chk.sv
`timescale 1ns/1ps
module dual_dma_arbiter_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 16'h2004,
  parameter bit                READ_ODD = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_pg_rd,
  input logic              ev_pg_wr,
  input logic              ev_steal,
  input logic              ev_realign,
  input logic              ev_smp_rd,
  input logic              ev_last_wr,
  input logic              busy,
  input logic              odd_cycle,
  input logic              cpu_rdy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              bus_rw,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_valid
);
  a_r3_read_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pg_rd |-> (odd_cycle == READ_ODD));

  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pg_rd |=> ev_pg_wr);

  a_r4_write_payload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pg_wr |-> (bus_addr == OUT_ADDR && !bus_rw && bus_wdata == $past(rd_data)));

  a_r7_realign_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_steal |=> (ev_realign && bus_addr == cpu_addr && !cpu_rdy));

  a_r7_resume_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_realign |=> (ev_pg_rd || ev_steal));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_wr |=> !busy);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_smp_rd |=> (smp_valid && smp_data == $past(rd_data)));
endmodule

bind dual_dma_arbiter dual_dma_arbiter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_ADDR(OUT_ADDR), .READ_ODD(READ_ODD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pg_rd(ev_pg_rd), .ev_pg_wr(ev_pg_wr),
  .ev_steal(ev_steal), .ev_realign(ev_realign), .ev_smp_rd(ev_smp_rd),
  .ev_last_wr(ev_last_wr), .busy(busy), .odd_cycle(odd_cycle),
  .cpu_rdy(cpu_rdy), .bus_addr(bus_addr), .cpu_addr(cpu_addr),
  .bus_rw(bus_rw), .bus_wdata(bus_wdata), .rd_data(rd_data),
  .smp_data(smp_data), .smp_valid(smp_valid)
);

// File: tb/dual_dma_arbiter_tb_top.sv
`timescale 1ns/1ps
module dual_dma_arbiter_tb_top;
  localparam logic [15:0] CPU_A = 16'h001D;
  localparam logic [15:0] SMP_A = 16'hC040;
  localparam logic [15:0] OUT_A = 16'h2004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [7:0]  trig_page = 8'h00;
  logic        smp_req = 1'b0;
  logic [15:0] smp_addr = SMP_A;
  logic [15:0] cpu_addr = CPU_A;
  logic [7:0]  rd_data;
  logic        cpu_rdy, bus_rw, smp_valid, odd_cycle;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, smp_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rd_data = mem_fn(bus_addr);

  dual_dma_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_page(trig_page),
    .smp_req(smp_req), .smp_addr(smp_addr), .cpu_addr(cpu_addr),
    .rd_data(rd_data), .cpu_rdy(cpu_rdy), .bus_addr(bus_addr),
    .bus_rw(bus_rw), .bus_wdata(bus_wdata), .smp_data(smp_data),
    .smp_valid(smp_valid), .odd_cycle(odd_cycle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk(cpu_rdy == 1'b1, "R1 rdy in reset", int'(cpu_rdy), 1);
    chk(bus_rw == 1'b1 && bus_addr == CPU_A, "R1 bus in reset", int'(bus_addr), int'(CPU_A));
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(smp_valid == 1'b0 && cpu_rdy == 1'b1, "R1 after reset", int'(smp_valid), 0);
  endtask

  task automatic test_parity();
    logic p0;
    @(negedge clk); #1; p0 = odd_cycle;
    @(negedge clk); #1;
    chk(odd_cycle != p0, "R3 parity toggles", int'(odd_cycle), int'(~p0));
  endtask

  task automatic test_sample_idle();
    @(negedge clk); smp_req = 1'b1; #1;
    chk(cpu_rdy == 1'b1, "R6 rdy in request cycle", int'(cpu_rdy), 1);
    @(negedge clk); smp_req = 1'b0; #1;
    chk(cpu_rdy == 1'b1, "R6 rdy at t+1", int'(cpu_rdy), 1);
    for (int k = 2; k <= 3; k++) begin
      @(negedge clk); #1;
      chk(!cpu_rdy && bus_addr == CPU_A, "R6 halt cycle", int'(bus_addr), int'(CPU_A));
    end
    @(negedge clk); #1;
    chk(!cpu_rdy && bus_rw && bus_addr == SMP_A, "R6 sample read at t+4", int'(bus_addr), int'(SMP_A));
    @(negedge clk); #1;
    chk(cpu_rdy && smp_valid, "R6 release and valid at t+5", int'({cpu_rdy, smp_valid}), 3);
    chk(smp_data == mem_fn(SMP_A), "R6 sample data", int'(smp_data), int'(mem_fn(SMP_A)));
    @(negedge clk); #1;
    chk(!smp_valid, "R6 valid is one cycle", int'(smp_valid), 0);
  endtask

  // want_odd: parity of the trigger cycle; inject: byte index to steal near (-1 none)
  task automatic run_copy(input logic [7:0] pg, input bit want_odd, input int inject,
                          input bit extra_trig);
    int idx, nsteal, first_rd, last_wr, inj_c, steal_c, c_done, align, exp_len;
    logic p0;
    idx = 0; nsteal = 0; first_rd = -1; last_wr = -1; inj_c = -1; steal_c = -10; c_done = -1;
    @(negedge clk); #1;
    if (odd_cycle != want_odd) @(negedge clk);
    trig_we = 1'b1; trig_page = pg; #1;
    p0 = odd_cycle;
    align = p0 ? 0 : 1;
    chk(cpu_rdy == 1'b0, "R2 rdy low with trigger", int'(cpu_rdy), 0);
    for (int c = 1; c < 3000 && c_done < 0; c++) begin
      @(negedge clk);
      trig_we = extra_trig && (c == 100);
      trig_page = extra_trig ? (pg ^ 8'h11) : pg;
      smp_req = (c == inj_c);
      #1;
      if (c <= 2)
        chk(bus_addr == CPU_A && bus_rw, "R2 halt cycles show cpu addr", int'(bus_addr), int'(CPU_A));
      if (cpu_rdy) begin
        c_done = c;
      end else if (!bus_rw) begin
        chk(last_wr != c - 1 && bus_addr == OUT_A, "R4 write target", int'(bus_addr), int'(OUT_A));
        chk(bus_wdata == mem_fn({pg, 8'(idx)}), "R8 copied byte intact", int'(bus_wdata),
            int'(mem_fn({pg, 8'(idx)})));
        idx++;
        last_wr = c;
      end else if (bus_addr == SMP_A) begin
        nsteal++;
        steal_c = c;
      end else if (bus_addr == CPU_A) begin
        if (c == steal_c + 1)
          chk(1'b1, "R7 realign shows cpu addr", 0, 0);
      end else begin
        if (first_rd < 0) begin
          first_rd = c;
          chk(c == 3 + align, "R3 first read cycle", c, 3 + align);
        end
        chk(bus_addr == {pg, 8'(idx)}, "R4 R7 R9 page read address", int'(bus_addr),
            int'({pg, 8'(idx)}));
        chk(odd_cycle == 1'b0, "R3 read on even cycle", int'(odd_cycle), 0);
        if (inject >= 0 && idx == inject && inj_c < 0) inj_c = c + 1;
      end
      if (smp_valid)
        chk(smp_data == mem_fn(SMP_A), "R8 sample byte intact", int'(smp_data), int'(mem_fn(SMP_A)));
    end
    trig_we = 1'b0; smp_req = 1'b0;
    exp_len = 515 + align + 2 * (inject >= 0 ? 1 : 0);
    chk(idx == 256, "R4 byte count", idx, 256);
    chk(c_done == last_wr + 1, "R5 release right after last write", c_done, last_wr + 1);
    chk(c_done == exp_len, "R5 R8 ready-low length", c_done, exp_len);
    chk(nsteal == (inject >= 0 ? 1 : 0), "R7 steal count", nsteal, inject >= 0 ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_parity();
    test_sample_idle();
    run_copy(8'h03, 1'b1, -1, 1'b0);
    run_copy(8'h5A, 1'b0, -1, 1'b0);
    run_copy(8'h07, 1'b1, 37, 1'b0);
    run_copy(8'h21, 1'b0, 200, 1'b0);
    run_copy(8'h44, 1'b1, -1, 1'b1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule